// File: doc/BRIEF.md
# Two-Wire Serial Debug Target Controller

This block is the target end of a two-wire debug link. One wire is the debug clock. The other is a single data wire that both sides share, and it idles high. The host changes the wire on falling clock edges and the target samples it on rising edges. A frame opens with a low start bit. A direction bit follows, then a two-bit select, then a turnaround slot. For a write the host then sends a payload of 8 instruction bits or 32 data bits, least significant bit first, with an odd parity bit after it. For a read the target takes the wire after the turnaround. It sends a low sync slot, 32 data bits least significant bit first, and its own parity bit, then lets go of the wire. A trailing turnaround slot ends every frame.

The debug register bank sits behind the block. It sees a held instruction value, a held data word with a one-cycle write strobe, a one-cycle read request with a data input, and a sticky parity-error flag. The serial link has no way to stall. So the written words are valid-only pulses with no ready, and the bank has no back-pressure: it must present read data by the end of the cycle in which the request is high. The pad that merges the output, its enable and the input sits outside the block.

Top module: `sdbg_target`

## Requirements
- R1: While reset is low and after it is released, the line enable is low, the instruction value is 0, the error flag is 0 and no strobe or read request is high.
- R2: In idle, a high line has no effect. A low line sampled on a rising edge is taken as a start bit.
- R3: After the start bit, the frame carries a direction bit (0 write, 1 read), then select bit 0, then select bit 1, then one turnaround slot. Select (bit0=0, bit1=1) addresses the instruction. Select (1,1) addresses the data word. The other two select codes are unsupported.
- R4: An instruction write carries 8 payload bits, LSB first, then parity. When parity is good, the instruction value updates and the instruction strobe is high for exactly one cycle, during the trailing turnaround slot. The instruction value changes at no other time.
- R5: A data write carries 32 payload bits, LSB first, then parity. When parity is good, the data word updates and the data strobe pulses for one cycle, during the trailing turnaround slot. A data write leaves the instruction value unchanged.
- R6: Write parity is 1 XOR all payload bits, which gives odd parity over payload plus parity. On a mismatch the error flag is set and no strobe is issued. The flag stays set through idle and clears when the next start bit is sampled.
- R7: On a read, the target drives the line for exactly 34 slots: the sync slot low, then 32 bits LSB first, then parity (1 XOR the 32 bits). The enable is low in every other slot. It changes only on falling edges.
- R8: A data read raises the read request for one cycle, during the sync slot. The read data input is taken at the end of that slot.
- R9: A read with the instruction select returns the instruction value zero-extended to 32 bits, with no read request.
- R10: An unsupported select on a write shifts 32 payload bits and parity and issues no strobe. On a read it returns 32 zero bits with parity 1 and no read request.
- R11: An asynchronous low reset in the middle of any frame returns the controller to idle at once. The line is released and the instruction value is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdio_i | input | 1 | Data wire as seen at the pad |
| sdio_o | output | 1 | Value the target drives onto the wire |
| sdio_oe | output | 1 | Target drives the wire when high |
| insn_o | output | 8 | Held instruction value |
| insn_wr_valid | output | 1 | One-cycle pulse after a good instruction write |
| dr_wdata | output | 32 | Held data word from the last good data write |
| dr_wr_valid | output | 1 | One-cycle pulse after a good data write |
| dr_rd_req | output | 1 | One-cycle read request during the sync slot |
| dr_rd_data | input | 32 | Read data, taken at the end of the request cycle |
| par_err | output | 1 | Sticky write-parity error flag |

## Verification
Write results show up one rising edge after the parity bit is sampled. The bench drives each bit on a falling edge and checks the strobes, held values and error flag 1 ns after the falling edge that opens the trailing turnaround slot. It checks again one slot later to confirm the strobe has dropped. Read bits change on falling edges, so the bench samples each driven slot 1 ns after its falling edge: the sync slot first (with the request), then 32 data slots, then parity, then the released slot. The clearing of the error flag is checked both before and after the rising edge that samples the next start bit.

// File: rtl/sdbg_pkg.sv
`timescale 1ns/1ps
package sdbg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RW, ST_SEL0, ST_SEL1, ST_TURN,
    ST_WPAY, ST_WPAR, ST_RSYNC, ST_RPAY, ST_RPAR, ST_TAIL
  } lnk_st_e;

  typedef enum logic [1:0] {
    SEL_BAD  = 2'd0,
    SEL_INSN = 2'd1,
    SEL_DATA = 2'd2
  } sel_e;

  function automatic sel_e sel_decode(input logic b0, input logic b1);
    if (!b0 && b1)      return SEL_INSN;
    else if (b0 && b1)  return SEL_DATA;
    else                return SEL_BAD;
  endfunction

endpackage

// File: rtl/sdbg_frame_fsm.sv
`timescale 1ns/1ps
module sdbg_frame_fsm
  import sdbg_pkg::*;
#(
  parameter int INSN_W = 8,
  parameter int DATA_W = 32
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    line_i,
  output lnk_st_e state_o,
  output logic    rw_o,
  output sel_e    sel_o,
  output logic    pay_last_o,
  output logic    start_o
);
  localparam int CNT_W = $clog2(DATA_W);

  lnk_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rw_q;
  logic             b0_q;
  sel_e             sel_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx   = (!rw_q && sel_q == SEL_INSN) ? CNT_W'(INSN_W - 1) : CNT_W'(DATA_W - 1);
  assign pay_last_o = (cnt_q == last_idx);
  assign start_o    = (state_q == ST_IDLE) && !line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      b0_q    <= 1'b0;
      sel_q   <= SEL_BAD;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (!line_i) state_q <= ST_RW;
        ST_RW:    begin rw_q <= line_i; state_q <= ST_SEL0; end
        ST_SEL0:  begin b0_q <= line_i; state_q <= ST_SEL1; end
        ST_SEL1:  begin sel_q <= sel_decode(b0_q, line_i); state_q <= ST_TURN; end
        ST_TURN:  begin cnt_q <= '0; state_q <= rw_q ? ST_RSYNC : ST_WPAY; end
        ST_WPAY:  begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (pay_last_o) state_q <= ST_WPAR;
        end
        ST_WPAR:  state_q <= ST_TAIL;
        ST_RSYNC: begin cnt_q <= '0; state_q <= ST_RPAY; end
        ST_RPAY:  begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (pay_last_o) state_q <= ST_RPAR;
        end
        ST_RPAR:  state_q <= ST_TAIL;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign rw_o    = rw_q;
  assign sel_o   = sel_q;

  AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !line_i) |=> (state_q == ST_RW)); // R2
  AST_READ_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN && rw_q) |=> (state_q == ST_RSYNC)); // R3
endmodule

// File: rtl/sdbg_wr_path.sv
`timescale 1ns/1ps
module sdbg_wr_path
  import sdbg_pkg::*;
#(
  parameter int INSN_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  lnk_st_e           state_i,
  input  sel_e              sel_i,
  input  logic              start_i,
  output logic [INSN_W-1:0] insn_o,
  output logic              insn_wr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_wr_o,
  output logic              err_o
);
  logic [DATA_W-1:0] sh_q;
  logic              par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      par_q     <= 1'b1;
      insn_o    <= '0;
      insn_wr_o <= 1'b0;
      data_o    <= '0;
      data_wr_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      insn_wr_o <= 1'b0;
      data_wr_o <= 1'b0;
      if (start_i) err_o <= 1'b0;
      unique case (state_i)
        ST_TURN: par_q <= 1'b1;
        ST_WPAY: begin
          sh_q  <= {line_i, sh_q[DATA_W-1:1]};
          par_q <= par_q ^ line_i;
        end
        ST_WPAR: begin
          if (line_i == par_q) begin
            if (sel_i == SEL_INSN) begin
              insn_o    <= sh_q[DATA_W-1 -: INSN_W];
              insn_wr_o <= 1'b1;
            end else if (sel_i == SEL_DATA) begin
              data_o    <= sh_q;
              data_wr_o <= 1'b1;
            end
          end else begin
            err_o <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_INSN_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    insn_wr_o |=> !insn_wr_o); // R4
  AST_INSN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(insn_o) |-> insn_wr_o); // R4
  AST_DATA_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_o |=> !data_wr_o); // R5
  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!insn_wr_o && !data_wr_o)); // R6
  AST_ERR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> (state_i == ST_RW)); // R6
endmodule

// File: rtl/sdbg_rd_path.sv
`timescale 1ns/1ps
module sdbg_rd_path
  import sdbg_pkg::*;
#(
  parameter int INSN_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lnk_st_e           state_i,
  input  logic              rw_i,
  input  sel_e              sel_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic              line_o,
  output logic              oe_o
);
  localparam int RUN_W = $clog2(DATA_W + 4);

  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic [DATA_W-1:0] load_val;

  always_comb begin
    unique case (sel_i)
      SEL_DATA: load_val = rd_data_i;
      SEL_INSN: load_val = DATA_W'(insn_i);
      default:  load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      par_q    <= 1'b1;
      rd_req_o <= 1'b0;
    end else begin
      rd_req_o <= (state_i == ST_TURN) && rw_i && (sel_i == SEL_DATA);
      if (state_i == ST_RSYNC) begin
        sh_q  <= load_val;
        par_q <= 1'b1;
      end else if (state_i == ST_RPAY) begin
        sh_q  <= sh_q >> 1;
        par_q <= par_q ^ sh_q[0];
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_o   <= 1'b0;
      line_o <= 1'b0;
    end else begin
      oe_o <= (state_i == ST_RSYNC) || (state_i == ST_RPAY) || (state_i == ST_RPAR);
      unique case (state_i)
        ST_RPAY: line_o <= sh_q[0];
        ST_RPAR: line_o <= par_q;
        default: line_o <= 1'b0;
      endcase
    end
  end

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= oe_o ? run_q + RUN_W'(1) : '0;
  end

  AST_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> !line_o); // R7
  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(DATA_W + 2)); // R7
  AST_REQ_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (oe_o && state_i == ST_RSYNC)); // R8
endmodule

// File: rtl/sdbg_target.sv
`timescale 1ns/1ps
module sdbg_target
  import sdbg_pkg::*;
#(
  parameter int INSN_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [INSN_W-1:0] insn_o,
  output logic              insn_wr_valid,
  output logic [DATA_W-1:0] dr_wdata,
  output logic              dr_wr_valid,
  output logic              dr_rd_req,
  input  logic [DATA_W-1:0] dr_rd_data,
  output logic              par_err
);
  lnk_st_e state;
  logic    rw;
  sel_e    sel;
  logic    pay_last;
  logic    start;

  sdbg_frame_fsm #(.INSN_W(INSN_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_i(sdio_i),
    .state_o(state), .rw_o(rw), .sel_o(sel),
    .pay_last_o(pay_last), .start_o(start)
  );

  sdbg_wr_path #(.INSN_W(INSN_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .line_i(sdio_i),
    .state_i(state), .sel_i(sel), .start_i(start),
    .insn_o(insn_o), .insn_wr_o(insn_wr_valid),
    .data_o(dr_wdata), .data_wr_o(dr_wr_valid), .err_o(par_err)
  );

  sdbg_rd_path #(.INSN_W(INSN_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .state_i(state), .rw_i(rw), .sel_i(sel),
    .insn_i(insn_o), .rd_data_i(dr_rd_data),
    .rd_req_o(dr_rd_req), .line_o(sdio_o), .oe_o(sdio_oe)
  );

  AST_NO_DRIVE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (!insn_wr_valid && !dr_wr_valid)); // R7
  AST_LAST_ONLY_IN_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WPAY && pay_last) |=> (state == ST_WPAR)); // R3
endmodule

// File: tb/sim_sdbg_target.sv
`timescale 1ns/1ps
module sim_sdbg_target;
  localparam int IW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host = 1'b1;
  logic [DW-1:0] rd_data = '0;
  logic          sdio_i, sdio_o, sdio_oe;
  logic [IW-1:0] insn;
  logic          insn_wr, dr_wr, rd_req, perr;
  logic [DW-1:0] wdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sdio_i = sdio_oe ? sdio_o : host;

  sdbg_target #(.INSN_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .insn_o(insn), .insn_wr_valid(insn_wr), .dr_wdata(wdata), .dr_wr_valid(dr_wr),
    .dr_rd_req(rd_req), .dr_rd_data(rd_data), .par_err(perr)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic opar(input logic [DW-1:0] v, input int len);
    logic p = 1'b1;
    for (int i = 0; i < len; i++) p = p ^ v[i];
    return p;
  endfunction

  function automatic logic [DW-1:0] pat(input int k);
    if (k < 32)       return 32'h1 << k;
    else if (k == 32) return 32'h0;
    else if (k == 33) return 32'hFFFF_FFFF;
    else if (k == 34) return 32'hA5A5_0F0F;
    else              return 32'h8000_0001;
  endfunction

  task automatic send(input logic b);
    @(negedge clk);
    host = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b1);
  endtask

  // write frame; returns 1 ns into the trailing turnaround slot
  task automatic wr_frame(input logic s0, input logic s1, input logic [DW-1:0] v,
                          input int len, input logic flip);
    send(1'b0); send(1'b0); send(s0); send(s1); send(1'b1);
    for (int i = 0; i < len; i++) send(v[i]);
    send(opar(v, len) ^ flip);
    send(1'b1);
    #1;
  endtask

  task automatic rd_frame(input logic s0, input logic s1, input logic [DW-1:0] exp,
                          input logic exp_req, input string req);
    logic [DW-1:0] got;
    logic p;
    logic oe_all;
    send(1'b0); send(1'b1); send(s0); send(s1); send(1'b1);
    @(negedge clk); #1;
    chk({req, " R7 sync slot"}, {29'd0, sdio_oe, sdio_o, rd_req}, {29'd0, 1'b1, 1'b0, exp_req});
    oe_all = 1'b1;
    got = '0;
    for (int i = 0; i < DW; i++) begin
      @(negedge clk); #1;
      got[i] = sdio_o;
      oe_all = oe_all & sdio_oe;
    end
    @(negedge clk); #1;
    p = sdio_o;
    oe_all = oe_all & sdio_oe;
    chk({req, " read data"}, got, exp);
    chk({req, " R7 read parity"}, {31'd0, p}, {31'd0, opar(exp, DW)});
    chk("R7 enable held over data", {31'd0, oe_all}, 32'd1);
    @(negedge clk); #1;
    chk("R7 released after parity", {31'd0, sdio_oe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #9;
    chk("R1 reset outputs", {22'd0, sdio_oe, insn, perr, insn_wr, dr_wr},
        32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(3); #1;
    chk("R1 after release", {23'd0, sdio_oe, insn, rd_req}, 32'd0);

    // R2 long high idle has no effect
    idle(20); #1;
    chk("R2 idle quiet", {28'd0, sdio_oe, insn_wr, dr_wr, perr}, 32'd0);

    // R4 / R9 / R3 sweep of every instruction value
    for (int v = 0; v < 256; v++) begin
      wr_frame(1'b0, 1'b1, DW'(v), IW, 1'b0);
      chk("R4 instruction write", {22'd0, insn_wr, dr_wr, insn}, {22'd0, 1'b1, 1'b0, 8'(v)});
      send(1'b1); #1;
      chk("R4 strobe one cycle", {31'd0, insn_wr}, 32'd0);
      rd_frame(1'b0, 1'b1, DW'(v), 1'b0, "R9");
    end

    // R5 / R8 data writes and reads
    for (int k = 0; k < 36; k++) begin
      wr_frame(1'b1, 1'b1, pat(k), DW, 1'b0);
      chk("R5 data strobe", {30'd0, dr_wr, insn_wr}, {30'd0, 1'b1, 1'b0});
      chk("R5 data word", wdata, pat(k));
      chk("R5 instruction untouched", {24'd0, insn}, 32'd255);
      send(1'b1); #1;
      chk("R5 strobe one cycle", {31'd0, dr_wr}, 32'd0);
      rd_data = pat(k) ^ (32'h0101_0101 * k);
      rd_frame(1'b1, 1'b1, rd_data, 1'b1, "R8");
    end

    // R6 parity errors
    wr_frame(1'b0, 1'b1, 32'h3C, IW, 1'b1);
    chk("R6 bad insn parity", {22'd0, perr, insn_wr, insn}, {22'd0, 1'b1, 1'b0, 8'hFF});
    idle(10); #1;
    chk("R6 error sticky", {31'd0, perr}, 32'd1);
    wr_frame(1'b1, 1'b1, 32'h1234_5678, DW, 1'b1);
    chk("R6 bad data parity", {30'd0, perr, dr_wr}, {30'd0, 1'b1, 1'b0});
    chk("R6 data word kept", wdata, pat(35));
    send(1'b0); #1;
    chk("R6 flag before start sampled", {31'd0, perr}, 32'd1);
    send(1'b0); #1;
    chk("R6 flag cleared by start", {31'd0, perr}, 32'd0);
    send(1'b0); send(1'b1); send(1'b1);
    for (int i = 0; i < IW; i++) send(logic'((8'h5A >> i) & 1));
    send(opar(32'h5A, IW)); send(1'b1); #1;
    chk("R6 good frame after error", {22'd0, insn_wr, perr, insn}, {22'd0, 1'b1, 1'b0, 8'h5A});
    idle(2);

    // R10 unsupported selects
    wr_frame(1'b0, 1'b0, 32'hDEAD_BEEF, DW, 1'b0);
    chk("R10 write sel 00", {21'd0, perr, insn_wr, dr_wr, insn}, {24'd0, 8'h5A});
    wr_frame(1'b1, 1'b0, 32'hCAFE_0001, DW, 1'b0);
    chk("R10 write sel 10", {21'd0, perr, insn_wr, dr_wr, insn}, {24'd0, 8'h5A});
    rd_data = 32'hFFFF_FFFF;
    rd_frame(1'b0, 1'b0, 32'h0, 1'b0, "R10");
    rd_frame(1'b1, 1'b0, 32'h0, 1'b0, "R10");

    // R11 reset in the middle of frames
    send(1'b0); send(1'b0); send(1'b0); send(1'b1); send(1'b1);
    send(1'b0); send(1'b1); send(1'b0);
    #1 rst_n = 1'b0;
    #1 chk("R11 reset mid write", {22'd0, sdio_oe, perr, insn}, 32'd0);
    host = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    send(1'b0); send(1'b1); send(1'b1); send(1'b1); send(1'b1);
    repeat (5) @(negedge clk);
    #1 chk("R11 driving before reset", {31'd0, sdio_oe}, 32'd1);
    rst_n = 1'b0;
    #1 chk("R11 line released at once", {31'd0, sdio_oe}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    wr_frame(1'b0, 1'b1, 32'h81, IW, 1'b0);
    chk("R11 recovery write", {23'd0, insn_wr, insn}, {23'd0, 1'b1, 8'h81});
    rd_frame(1'b0, 1'b1, 32'h81, 1'b0, "R11 recovery");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule